// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel characters into frames on a single asynchronous serial line. A character is written into a one-entry holding register through a valid/empty handshake. When the line is idle and the far end permits sending, the character moves into a shift register and goes out as a frame. Each frame has a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop period of one, one and a half or two bit times.

Bit timing comes from a 16x tick. The tick is made by dividing the input clock by a 16-bit divisor. A divisor of zero counts as one. The divider is held in reset while the line is idle, so every frame starts on a clean tick boundary. The character settings and the divisor are captured when a frame starts. While a frame is on the line, the next character can already be written into the holding register.

Top module: `async_tx`

## Requirements
- R1: After reset `txd` is 1, `busy` is 0 and `hold_empty` is 1. Whenever `busy` is 0, `txd` is 1.
- R2: A frame begins with `txd` low for one bit time. The data bits follow, least significant bit first. The bit count is 5 + `cfg_len`, so 00 gives 5 bits and 11 gives 8 bits.
- R3: `cfg_parity` selects the parity mode: 00 or 11 gives no parity bit, 01 gives even parity, 10 gives odd parity. With even parity, the data bits and the parity bit together hold an even number of ones. With odd parity they hold an odd number. The parity bit is sent right after the last data bit.
- R4: `cfg_stop` selects the stop length. 00 holds the line high for 16 ticks, 01 for 24 ticks, and 10 or 11 for 32 ticks. `busy` falls on the edge where the stop period ends.
- R5: While a frame is on the line, a tick occurs once every D clock cycles, where D is the effective divisor. Every start, data and parity bit lasts exactly 16·D cycles. `txd` changes only at bit boundaries.
- R6: A divisor of 0 behaves exactly like a divisor of 1.
- R7: The length, parity, stop and divisor settings are captured at the edge where the frame starts. Changing them while the frame is on the line has no effect on that frame.
- R8: A frame starts only when the holding register is full, `cts` is 1 and the line is idle. If `cts` drops during a frame, that frame still completes, but the next held character waits.
- R9: `hold_empty` rises on the same edge that a held character moves into the shift register. A new character can then be accepted while the frame is still being sent.
- R10: If `in_valid` is asserted while the holding register is full, the write is ignored. The held character is neither overwritten nor sent twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_len | input | 2 | Data bit count minus 5 |
| cfg_parity | input | 2 | Parity mode: 00/11 none, 01 even, 10 odd |
| cfg_stop | input | 2 | Stop length: 00 one bit, 01 one and a half, 1x two |
| divisor | input | DIV_W | Clock cycles per 16x tick; 0 is treated as 1 |
| in_valid | input | 1 | Write strobe for the holding register |
| in_data | input | 8 | Character to send |
| cts | input | 1 | Clear to send; gates the start of a frame |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | A frame is on the line |
| hold_empty | output | 1 | Holding register can take a character |

## Verification
The assertions assume `rst_n` is synchronous and that `cts` and `in_valid` change only between clock edges. The property for R5 assumes the divisor captured at frame start stays the one the divider uses for the whole frame. The stimulus follows these rules. It writes a character only after it has seen `hold_empty` high at a falling edge. It changes settings in a test only after the affected frame has visibly started, or while no character is held. The bench reads no internal state: every frame is decoded from `txd` by sampling in the middle of each bit, and the length of the stop period is measured as the time until `busy` falls.

// File: rtl/tx_pkg.sv
package tx_pkg;

  localparam int TX_DATA_W   = 8;
  localparam int TX_MIN_BITS = 5;
  localparam int TX_IDX_W    = $clog2(TX_DATA_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  // Number of data bits selected by the two-bit length code.
  function automatic int data_bits(input logic [1:0] len);
    return TX_MIN_BITS + int'(len);
  endfunction

  // Mask with the low data_bits(len) positions set.
  function automatic logic [TX_DATA_W-1:0] len_mask(input logic [1:0] len);
    logic [TX_DATA_W-1:0] m;
    for (int i = 0; i < TX_DATA_W; i++) begin
      m[i] = (i < data_bits(len));
    end
    return m;
  endfunction

  // Stop period in ticks for a given oversampling ratio.
  function automatic int stop_ticks(input logic [1:0] stop, input int ovs);
    case (stop)
      2'b00:   return ovs;
      2'b01:   return ovs + ovs / 2;
      default: return 2 * ovs;
    endcase
  endfunction

  function automatic logic par_enabled(input logic [1:0] mode);
    return (mode == 2'b01) || (mode == 2'b10);
  endfunction

  // Even mode: bit equals XOR of data. Odd mode: inverted.
  function automatic logic par_value(input logic [TX_DATA_W-1:0] data,
                                     input logic [1:0] len,
                                     input logic [1:0] mode);
    return (^(data & len_mask(len))) ^ (mode == 2'b10);
  endfunction

endpackage

// File: rtl/tx_baud_div.sv
module tx_baud_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick,
  output logic [DIV_W-1:0] div_q
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction

  assign lim  = eff_div(div_q);
  assign tick = run && (cnt == (lim - DIV_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      div_q <= '0;
    end else if (!run) begin
      cnt   <= '0;
      div_q <= divisor;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

endmodule

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (wr_en && !full) begin
      full <= 1'b1;
      data <= wr_data;
    end
  end

endmodule

// File: rtl/tx_frame_fsm.sv
module tx_frame_fsm
  import tx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 launch,
  input  logic [TX_DATA_W-1:0] data,
  input  logic [1:0]           cfg_len,
  input  logic [1:0]           cfg_parity,
  input  logic [1:0]           cfg_stop,
  output logic                 txd,
  output logic                 busy,
  output logic                 bit_done
);

  localparam int TCW = $clog2(2 * OVS + 1);

  tx_state_e             state;
  logic [TCW-1:0]        tcnt;
  logic [TCW-1:0]        stop_last;
  logic [TCW-1:0]        cur_last;
  logic [TX_DATA_W-1:0]  shreg;
  logic [TX_IDX_W-1:0]   bidx;
  logic [TX_IDX_W-1:0]   last_idx;
  logic                  par_en;
  logic                  par_bit;

  assign busy     = (state != ST_IDLE);
  assign cur_last = (state == ST_STOP) ? stop_last : TCW'(OVS - 1);
  assign bit_done = busy && tick && (tcnt == cur_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      txd       <= 1'b1;
      tcnt      <= '0;
      stop_last <= '0;
      shreg     <= '0;
      bidx      <= '0;
      last_idx  <= '0;
      par_en    <= 1'b0;
      par_bit   <= 1'b0;
    end else if (state == ST_IDLE) begin
      txd <= 1'b1;
      if (launch) begin
        state     <= ST_START;
        txd       <= 1'b0;
        tcnt      <= '0;
        bidx      <= '0;
        shreg     <= data;
        last_idx  <= TX_IDX_W'(data_bits(cfg_len) - 1);
        par_en    <= par_enabled(cfg_parity);
        par_bit   <= par_value(data, cfg_len, cfg_parity);
        stop_last <= TCW'(stop_ticks(cfg_stop, OVS) - 1);
      end
    end else if (tick) begin
      tcnt <= bit_done ? '0 : tcnt + TCW'(1);
      if (bit_done) begin
        case (state)
          ST_START: begin
            state <= ST_DATA;
            txd   <= shreg[0];
            shreg <= shreg >> 1;
          end
          ST_DATA: begin
            if (bidx == last_idx) begin
              state <= par_en ? ST_PAR : ST_STOP;
              txd   <= par_en ? par_bit : 1'b1;
            end else begin
              bidx  <= bidx + TX_IDX_W'(1);
              txd   <= shreg[0];
              shreg <= shreg >> 1;
            end
          end
          ST_PAR: begin
            state <= ST_STOP;
            txd   <= 1'b1;
          end
          default: begin
            state <= ST_IDLE;
            txd   <= 1'b1;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/async_tx.sv
module async_tx
  import tx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cfg_len,
  input  logic [1:0]           cfg_parity,
  input  logic [1:0]           cfg_stop,
  input  logic [DIV_W-1:0]     divisor,
  input  logic                 in_valid,
  input  logic [TX_DATA_W-1:0] in_data,
  input  logic                 cts,
  output logic                 txd,
  output logic                 busy,
  output logic                 hold_empty
);

  logic                 tick_w;
  logic [DIV_W-1:0]     div_q_w;
  logic                 hold_full;
  logic [TX_DATA_W-1:0] hold_data;
  logic                 launch;
  logic                 bit_done_w;

  assign launch     = hold_full && cts && !busy;
  assign hold_empty = !hold_full;

  tx_baud_div #(.DIV_W(DIV_W)) i_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .divisor (divisor),
    .tick    (tick_w),
    .div_q   (div_q_w)
  );

  tx_hold_reg #(.W(TX_DATA_W)) i_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (in_valid),
    .wr_data (in_data),
    .take    (launch),
    .full    (hold_full),
    .data    (hold_data)
  );

  tx_frame_fsm #(.OVS(OVS)) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_w),
    .launch     (launch),
    .data       (hold_data),
    .cfg_len    (cfg_len),
    .cfg_parity (cfg_parity),
    .cfg_stop   (cfg_stop),
    .txd        (txd),
    .busy       (busy),
    .bit_done   (bit_done_w)
  );

endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cts,
  input logic             in_valid,
  input logic             txd,
  input logic             busy,
  input logic             hold_empty,
  input logic             tick,
  input logic             bit_done,
  input logic [DIV_W-1:0] div_q,
  input logic [7:0]       hold_data
);

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R1

  AST_START_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd); // R2

  AST_LINE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(bit_done)) |-> $stable(txd)); // R5

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick && div_q > DIV_W'(1)) |=> !tick); // R5

  AST_ZERO_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && div_q <= DIV_W'(1)) |-> tick); // R6

  AST_CTS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cts)); // R8

  AST_EMPTY_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> hold_empty); // R9

  AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_empty && in_valid) |=> $stable(hold_data)); // R10

endmodule

bind async_tx async_tx_chk #(.DIV_W(DIV_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cts        (cts),
  .in_valid   (in_valid),
  .txd        (txd),
  .busy       (busy),
  .hold_empty (hold_empty),
  .tick       (tick_w),
  .bit_done   (bit_done_w),
  .div_q      (div_q_w),
  .hold_data  (hold_data)
);

// File: tb/test_async_tx.sv
module test_async_tx;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 16;

  typedef struct {
    logic [7:0]       d;
    logic [1:0]       len;
    logic [1:0]       par;
    logic [1:0]       stop;
    logic [DIV_W-1:0] dv;
  } item_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       cfg_len = 2'b11;
  logic [1:0]       cfg_parity = 2'b00;
  logic [1:0]       cfg_stop = 2'b00;
  logic [DIV_W-1:0] divisor = 16'd1;
  logic             in_valid = 1'b0;
  logic [7:0]       in_data = 8'h00;
  logic             cts = 1'b1;
  logic             txd;
  logic             busy;
  logic             hold_empty;

  int    total = 0;
  int    bad = 0;
  int    cyc = 0;
  item_t q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  async_tx #(.DIV_W(DIV_W)) i_async_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_len    (cfg_len),
    .cfg_parity (cfg_parity),
    .cfg_stop   (cfg_stop),
    .divisor    (divisor),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .cts        (cts),
    .txd        (txd),
    .busy       (busy),
    .hold_empty (hold_empty)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: wait for room, write one character, record what must appear.
  task automatic send(input logic [7:0] d, input logic [1:0] len,
                      input logic [1:0] par, input logic [1:0] stop,
                      input logic [DIV_W-1:0] dv);
    item_t it;
    while (!hold_empty) @(negedge clk);
    cfg_len    = len;
    cfg_parity = par;
    cfg_stop   = stop;
    divisor    = dv;
    in_data    = d;
    in_valid   = 1'b1;
    it.d = d; it.len = len; it.par = par; it.stop = stop; it.dv = dv;
    q.push_back(it);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_drained();
    while (busy || !hold_empty || q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: decode each frame from txd and compare with the queue head.
  initial begin : monitor
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin : frame
        item_t      it;
        int         t0, dd, bt, nb, stp, exp_len;
        logic       pe, expp;
        logic [7:0] got, msk;
        t0 = cyc;
        if (q.size() == 0) begin
          chk("R10 unexpected frame", 1, 0);
          while (busy) @(negedge clk);
        end else begin
          it  = q.pop_front();
          chk("R9 hold_empty at frame start", int'(hold_empty), 1);
          dd  = (it.dv == '0) ? 1 : int'(it.dv);
          bt  = 16 * dd;
          nb  = 5 + int'(it.len);
          pe  = (it.par == 2'b01) || (it.par == 2'b10);
          stp = (it.stop == 2'b00) ? 16 : (it.stop == 2'b01) ? 24 : 32;
          msk = 8'hFF >> (8 - nb);
          repeat (bt / 2) @(negedge clk);
          chk("R2 start bit low", int'(txd), 0);
          got = 8'h00;
          for (int i = 0; i < nb; i++) begin
            repeat (bt) @(negedge clk);
            got[i] = txd;
          end
          chk("R2 data bits", int'(got), int'(it.d & msk));
          if (pe) begin
            repeat (bt) @(negedge clk);
            expp = (^got) ^ (it.par == 2'b10);
            chk("R3 parity bit", int'(txd), int'(expp));
          end
          repeat (bt) @(negedge clk);
          chk("R4 stop level", int'(txd), 1);
          while (busy) @(negedge clk);
          exp_len = (1 + nb + (pe ? 1 : 0)) * bt + stp * dd;
          chk("R4 R5 frame length", cyc - t0, exp_len);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset txd", int'(txd), 1);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset hold_empty", int'(hold_empty), 1);

    // 8 bits, no parity, 1 stop, back to back (R9 overlap).
    send(8'hA5, 2'b11, 2'b00, 2'b00, 16'd2);
    send(8'h3C, 2'b11, 2'b00, 2'b00, 16'd2);
    wait_drained();
    // 5 bits, even parity, 1.5 stop, divisor 0 (R6).
    send(8'hF3, 2'b00, 2'b01, 2'b01, 16'd0);
    wait_drained();
    // 7 bits, odd parity, 2 stop (R3, R4).
    send(8'h5B, 2'b10, 2'b10, 2'b10, 16'd3);
    wait_drained();
    // 6 bits, even parity, code 11 stop.
    send(8'h2E, 2'b01, 2'b01, 2'b11, 16'd1);
    wait_drained();
    // Parity code 11 means none; odd parity with all-ones data.
    send(8'hFF, 2'b11, 2'b11, 2'b00, 16'd1);
    send(8'hFF, 2'b11, 2'b10, 2'b00, 16'd1);
    wait_drained();

    // R7: settings changed after the frame starts must not matter.
    send(8'h96, 2'b11, 2'b01, 2'b00, 16'd2);
    while (!busy) @(negedge clk);
    cfg_len = 2'b00; cfg_parity = 2'b10; cfg_stop = 2'b10; divisor = 16'd5;
    wait_drained();

    // R8 and R10: cts low holds the character; a second write is dropped.
    cts = 1'b0;
    send(8'h81, 2'b11, 2'b00, 2'b00, 16'd1);
    in_data = 8'h7E; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (100) @(negedge clk);
    chk("R8 no start without cts", int'(busy), 0);
    chk("R8 line idle without cts", int'(txd), 1);
    chk("R10 held char kept full", int'(hold_empty), 0);
    cts = 1'b1;
    wait_drained();
    repeat (300) @(negedge clk);
    chk("R10 dropped write not sent", int'(busy), 0);

    // R8: cts drop mid-frame lets the frame finish but holds the next.
    send(8'h4D, 2'b11, 2'b01, 2'b00, 16'd1);
    while (!busy) @(negedge clk);
    cts = 1'b0;
    send(8'hC2, 2'b10, 2'b00, 2'b01, 16'd1);
    while (busy) @(negedge clk);
    repeat (50) @(negedge clk);
    chk("R8 next frame held", int'(busy), 0);
    chk("R8 next char still held", int'(hold_empty), 0);
    cts = 1'b1;
    wait_drained();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule